// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block lets a byte array inside the chip answer on a two-wire serial bus as if it were a serial EEPROM. The bus lines are brought into the system clock domain, and START, repeated START and STOP are recognised there. A device code is accepted only when its upper nibble is the fixed family value and its lower three bits equal three strap inputs. The block then takes a two-byte word address and serves byte writes, page writes, random reads and sequential reads.

Write data first goes into a page-sized holding buffer. On a clean STOP it is copied into the array, and a busy counter then runs for a set number of system clocks. While that counter runs the block answers nothing, so a master can poll for the end of the write cycle. A protect input blocks every change to the array. Under protect the block still acknowledges the device code and the address bytes, but not the data bytes. The block only ever pulls the data line low and never drives it high.

Top module: `twi_eeprom`

## Requirements
- R1: A device code byte is acknowledged only when bits 7..4 equal 1010 and bits 3..1 equal `strapSel[2:0]`. Bit 0 is the read/write flag, with 1 meaning read. For any other code the data line stays released through the acknowledge clock.
- R2: The word address arrives as two bytes with the high byte first. Address bits above the array size are ignored, and a byte write stores its data at the resulting location.
- R3: A page write holds up to `PAGE_BYTES` data bytes, 32 by default, and stores each at the next address. The address wraps inside its own page and never moves into the next page.
- R4: The array changes only on a STOP that follows a whole number of data bytes. If a STOP arrives partway through a byte, or a repeated START arrives, the buffered data is dropped and no write cycle starts.
- R5: After a write is committed, the device code goes unacknowledged for `BUSY_CYCLES` system clocks and is acknowledged again once that time has passed.
- R6: While `wrProtect` is high, the device code and both address bytes are acknowledged, data bytes are not, the array stays unchanged and no busy period starts.
- R7: A random read works as follows: a write device code, the two address bytes, a repeated START, then a read device code. It returns the byte at that address, most significant bit first.
- R8: A sequential read returns successive bytes while the master acknowledges. The address wraps from the top of the array to location 0.
- R9: When the master does not acknowledge a read byte, the slave releases the data line and stays off the bus until the next START.
- R10: `sdaPullLow` high means the pad is pulled low. It is low after reset, and every array location reads 8'hFF after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| sclIn | input | 1 | Bus clock as seen at the pad |
| sdaIn | input | 1 | Bus data as seen at the pad (wired value) |
| strapSel | input | 3 | Strap value expected in device code bits 3..1 |
| wrProtect | input | 1 | High blocks all array writes; an unconnected pad should be tied low |
| sdaPullLow | output | 1 | High pulls the data line low (open-drain enable) |

## Verification
The bench builds the block with a 128-byte array, an 8-byte page and a 400-cycle busy time. The small page lets a five-byte write starting near the end of a page show the wrap back to the page start. The small array lets a sequential read run past the top location and back to 0 within a few bytes. The busy time is short enough that the bench can send one poll inside the busy window, see it refused, wait out the window and see a later poll accepted.

// File: rtl/twi_eeprom_pkg.sv
package twi_eeprom_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECV,
    ST_ACK,
    ST_SEND,
    ST_MACK
  } busState_t;

  typedef enum logic [1:0] {
    PH_DEV,
    PH_AHI,
    PH_ALO,
    PH_DATA
  } bytePhase_t;

  typedef struct packed {
    logic loadHi;
    logic loadLo;
    logic bufWrite;
    logic rdAdvance;
    logic commit;
    logic discard;
  } dpCmd_t;

  localparam logic [3:0] DEV_FAMILY = 4'b1010;

endpackage

// File: rtl/twi_eeprom_ctrl.sv
module twi_eeprom_ctrl
  import twi_eeprom_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] strapSel,
  input  logic       wrProtect,
  input  logic       busy,
  input  logic [7:0] rdByte,
  output dpCmd_t     cmd,
  output logic [7:0] wrByte,
  output logic       sdaLow
);

  logic [1:0] sclSync, sdaSync;
  logic       sclPrev, sdaPrev;
  logic       sclS, sdaS;
  logic       sclRise, sclFall, startSeen, stopSeen;

  busState_t  state, nState;
  bytePhase_t phase, nPhase;
  logic [7:0] shReg, nSh;
  logic [3:0] bitCnt, nCnt;
  logic       rwRead, nRw;
  logic       mAck, nMAck;
  logic       nSda;
  logic       devMatch;

  assign sclS      = sclSync[1];
  assign sdaS      = sdaSync[1];
  assign sclRise   = sclS & ~sclPrev;
  assign sclFall   = ~sclS & sclPrev;
  assign startSeen = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopSeen  = sclS & sclPrev & ~sdaPrev & sdaS;
  assign devMatch  = (shReg[7:1] == {DEV_FAMILY, strapSel});
  assign wrByte    = shReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  always_comb begin
    nState = state;
    nPhase = phase;
    nSh    = shReg;
    nCnt   = bitCnt;
    nRw    = rwRead;
    nMAck  = mAck;
    nSda   = sdaLow;
    cmd    = '0;
    if (startSeen) begin
      nState      = ST_RECV;
      nPhase      = PH_DEV;
      nCnt        = 4'd0;
      nRw         = 1'b0;
      nSda        = 1'b0;
      cmd.discard = 1'b1;
    end else if (stopSeen) begin
      nState = ST_IDLE;
      nSda   = 1'b0;
      if (state == ST_RECV && phase == PH_DATA && bitCnt <= 4'd1) cmd.commit = 1'b1;
      else cmd.discard = 1'b1;
    end else begin
      case (state)
        ST_RECV: begin
          if (sclRise && bitCnt < 4'd8) begin
            nSh  = {shReg[6:0], sdaS};
            nCnt = bitCnt + 4'd1;
          end else if (sclFall && bitCnt == 4'd8) begin
            nCnt = 4'd0;
            case (phase)
              PH_DEV: begin
                if (devMatch && !busy) begin
                  nSda   = 1'b1;
                  nState = ST_ACK;
                  nRw    = shReg[0];
                  nPhase = PH_AHI;
                end else begin
                  nState = ST_IDLE;
                end
              end
              PH_AHI: begin
                cmd.loadHi = 1'b1;
                nSda       = 1'b1;
                nState     = ST_ACK;
                nPhase     = PH_ALO;
              end
              PH_ALO: begin
                cmd.loadLo = 1'b1;
                nSda       = 1'b1;
                nState     = ST_ACK;
                nPhase     = PH_DATA;
              end
              default: begin
                if (wrProtect) begin
                  nState = ST_IDLE;
                end else begin
                  cmd.bufWrite = 1'b1;
                  nSda         = 1'b1;
                  nState       = ST_ACK;
                end
              end
            endcase
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            nSda = 1'b0;
            if (rwRead) begin
              nState        = ST_SEND;
              nSh           = rdByte;
              nSda          = ~rdByte[7];
              nCnt          = 4'd1;
              cmd.rdAdvance = 1'b1;
            end else begin
              nState = ST_RECV;
              nCnt   = 4'd0;
            end
          end
        end
        ST_SEND: begin
          if (sclFall) begin
            if (bitCnt == 4'd8) begin
              nSda   = 1'b0;
              nState = ST_MACK;
            end else begin
              nSda = ~shReg[6];
              nSh  = {shReg[6:0], 1'b0};
              nCnt = bitCnt + 4'd1;
            end
          end
        end
        ST_MACK: begin
          if (sclRise) begin
            nMAck = ~sdaS;
          end else if (sclFall) begin
            if (mAck) begin
              nState        = ST_SEND;
              nSh           = rdByte;
              nSda          = ~rdByte[7];
              nCnt          = 4'd1;
              cmd.rdAdvance = 1'b1;
            end else begin
              nState = ST_IDLE;
              nSda   = 1'b0;
            end
          end
        end
        default: begin
          nSda = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      phase  <= PH_DEV;
      shReg  <= '0;
      bitCnt <= '0;
      rwRead <= 1'b0;
      mAck   <= 1'b0;
      sdaLow <= 1'b0;
    end else begin
      state  <= nState;
      phase  <= nPhase;
      shReg  <= nSh;
      bitCnt <= nCnt;
      rwRead <= nRw;
      mAck   <= nMAck;
      sdaLow <= nSda;
    end
  end

  // R10: the pull-down only moves while the bus clock is low, or right after a bus condition
  p_sda_moves_scl_low_r10: assert property (@(posedge clk) disable iff (!rstN)
    (sdaLow != $past(sdaLow)) |-> (!sclS || $past(startSeen || stopSeen)));

  // R5: a device code judged during the busy period is never acknowledged
  p_busy_nack_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RECV && phase == PH_DEV && sclFall && bitCnt == 4'd8 && busy) |=> !sdaLow);

  // R9: after a master NACK the slave is idle and released
  p_release_after_nack_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_MACK && sclFall && !mAck && !startSeen && !stopSeen) |=> (!sdaLow && state == ST_IDLE));

endmodule

// File: rtl/twi_eeprom_dp.sv
module twi_eeprom_dp
  import twi_eeprom_pkg::*;
#(
  parameter int MEM_BYTES   = 512,
  parameter int PAGE_BYTES  = 32,
  parameter int BUSY_CYCLES = 2000
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpCmd_t     cmd,
  input  logic [7:0] wrByte,
  output logic [7:0] rdByte,
  output logic       busy
);

  localparam int ADDR_W = $clog2(MEM_BYTES);
  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int CNT_W  = $clog2(BUSY_CYCLES + 1);

  logic [7:0]        addrHi;
  logic [ADDR_W-1:0] addrPtr;
  logic [7:0]        pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] bufValid;
  logic [PAGE_BYTES-1:0] slotHit;
  logic [CNT_W-1:0]  busyCnt;
  logic [7:0]        mem [MEM_BYTES];
  logic              havePending;

  assign havePending = |bufValid;
  assign busy        = (busyCnt != '0);
  assign rdByte      = mem[addrPtr];

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    assign slotHit[g] = cmd.bufWrite && (addrPtr[OFF_W-1:0] == OFF_W'(g));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrHi  <= '0;
      addrPtr <= '0;
    end else begin
      if (cmd.loadHi) addrHi <= wrByte;
      if (cmd.loadLo) addrPtr <= ADDR_W'({addrHi, wrByte});
      else if (cmd.bufWrite)
        addrPtr <= {addrPtr[ADDR_W-1:OFF_W], OFF_W'(addrPtr[OFF_W-1:0] + 1'b1)};
      else if (cmd.rdAdvance) addrPtr <= addrPtr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufValid <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) pageBuf[i] <= '0;
    end else if (cmd.commit || cmd.discard) begin
      bufValid <= '0;
    end else begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (slotHit[i]) begin
          bufValid[i] <= 1'b1;
          pageBuf[i]  <= wrByte;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
    end else if (cmd.commit) begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (bufValid[i]) mem[{addrPtr[ADDR_W-1:OFF_W], OFF_W'(i)}] <= pageBuf[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyCnt <= '0;
    else if (cmd.commit && havePending) busyCnt <= CNT_W'(BUSY_CYCLES);
    else if (busy) busyCnt <= busyCnt - 1'b1;
  end

  // R5: no data is taken into the buffer while the write cycle runs
  p_busy_blocks_data_r5: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !cmd.bufWrite);

  // R4: a commit with buffered data always opens the busy window
  p_commit_opens_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.commit && havePending) |=> busy);

  // R5: the busy window shrinks by one every clock
  p_busy_countdown_r5: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (busyCnt == $past(busyCnt) - 1'b1));

  // R3: buffering a data byte never moves the pointer to another page
  p_page_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    cmd.bufWrite |=> (addrPtr[ADDR_W-1:OFF_W] == $past(addrPtr[ADDR_W-1:OFF_W])));

endmodule

// File: rtl/twi_eeprom.sv
module twi_eeprom
  import twi_eeprom_pkg::*;
#(
  parameter int MEM_BYTES   = 512,
  parameter int PAGE_BYTES  = 32,
  parameter int BUSY_CYCLES = 2000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] strapSel,
  input  logic       wrProtect,
  output logic       sdaPullLow
);

  dpCmd_t     cmd;
  logic [7:0] wrByte;
  logic [7:0] rdByte;
  logic       busy;

  twi_eeprom_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .sclIn     (sclIn),
    .sdaIn     (sdaIn),
    .strapSel  (strapSel),
    .wrProtect (wrProtect),
    .busy      (busy),
    .rdByte    (rdByte),
    .cmd       (cmd),
    .wrByte    (wrByte),
    .sdaLow    (sdaPullLow)
  );

  twi_eeprom_dp #(
    .MEM_BYTES   (MEM_BYTES),
    .PAGE_BYTES  (PAGE_BYTES),
    .BUSY_CYCLES (BUSY_CYCLES)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .cmd    (cmd),
    .wrByte (wrByte),
    .rdByte (rdByte),
    .busy   (busy)
  );

endmodule

// File: tb/twi_eeprom_tb.sv
`timescale 1ns/1ps
module twi_eeprom_tb;

  localparam int MEM  = 128;
  localparam int PAGE = 8;
  localparam int BUSY = 400;
  localparam int HP   = 10;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclDrv = 1'b1;
  logic sdaDrv = 1'b1;
  logic wrProtect = 1'b0;
  logic sdaPullLow;
  logic sdaBus;

  assign sdaBus = sdaDrv & ~sdaPullLow;

  always #2.5 clk = ~clk;

  twi_eeprom #(.MEM_BYTES(MEM), .PAGE_BYTES(PAGE), .BUSY_CYCLES(BUSY)) u_dut (
    .clk        (clk),
    .rstN       (rstN),
    .sclIn      (sclDrv),
    .sdaIn      (sdaBus),
    .strapSel   (STRAP),
    .wrProtect  (wrProtect),
    .sdaPullLow (sdaPullLow)
  );

  typedef struct {
    logic [7:0] v;
    string      req;
  } item_t;

  item_t      expQ[$];
  logic [7:0] obsQ[$];
  logic [7:0] model [MEM];
  logic [7:0] wbuf [8];
  int checks = 0;
  int errors = 0;

  task automatic expectVal(input logic [7:0] v, input string req);
    item_t it;
    it.v = v;
    it.req = req;
    expQ.push_back(it);
  endtask

  task automatic observe(input logic [7:0] v);
    obsQ.push_back(v);
  endtask

  // monitor: pops observed results and compares them with the expected queue
  initial begin
    forever begin
      @(negedge clk);
      while (obsQ.size() > 0) begin
        logic [7:0] o;
        item_t e;
        o = obsQ.pop_front();
        checks++;
        if (expQ.size() == 0) begin
          errors++;
          $display("FAIL unexpected-result actual %02h expected none", o);
        end else begin
          e = expQ.pop_front();
          if (o !== e.v) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", e.req, o, e.v);
          end
        end
      end
    end
  end

  task automatic hp();
    repeat (HP) @(negedge clk);
  endtask

  task automatic startCond();
    sdaDrv = 1'b1; hp();
    sclDrv = 1'b1; hp();
    sdaDrv = 1'b0; hp();
    sclDrv = 1'b0; hp();
  endtask

  task automatic stopCond();
    sdaDrv = 1'b0; hp();
    sclDrv = 1'b1; hp();
    sdaDrv = 1'b1; hp();
  endtask

  task automatic writeBit(input logic b);
    sdaDrv = b; hp();
    sclDrv = 1'b1; hp();
    sclDrv = 1'b0;
  endtask

  // ack result encoded 0 = acknowledged, 1 = not acknowledged
  task automatic sendByte(input logic [7:0] b, input logic expNack, input string req);
    expectVal({7'b0, expNack}, req);
    for (int i = 7; i >= 0; i--) writeBit(b[i]);
    sdaDrv = 1'b1; hp();
    sclDrv = 1'b1; hp();
    observe({7'b0, sdaBus});
    sclDrv = 1'b0;
  endtask

  task automatic readByte(input logic last, input logic [7:0] expV, input string req);
    logic [7:0] v;
    v = '0;
    expectVal(expV, req);
    sdaDrv = 1'b1;
    for (int i = 0; i < 8; i++) begin
      hp();
      sclDrv = 1'b1; hp();
      v = {v[6:0], sdaBus};
      sclDrv = 1'b0;
    end
    observe(v);
    sdaDrv = last; hp();
    sclDrv = 1'b1; hp();
    sclDrv = 1'b0;
    sdaDrv = 1'b1; hp();
    if (last) begin
      expectVal(8'h00, "R9");
      observe({7'b0, sdaPullLow});
    end
  endtask

  function automatic logic [7:0] devCode(input logic rw);
    return {4'b1010, STRAP, rw};
  endfunction

  task automatic writeBytes(input logic [15:0] a, input int n, input string req);
    int ea, base, off;
    startCond();
    sendByte(devCode(1'b0), 1'b0, "R1");
    sendByte(a[15:8], 1'b0, "R2");
    sendByte(a[7:0], 1'b0, "R2");
    for (int k = 0; k < n; k++) sendByte(wbuf[k], 1'b0, req);
    stopCond();
    ea = int'(a) % MEM;
    off = ea % PAGE;
    base = ea - off;
    for (int k = 0; k < n; k++) model[base + ((off + k) % PAGE)] = wbuf[k];
  endtask

  task automatic readSeq(input logic [15:0] a, input int n, input string req);
    int ea;
    ea = int'(a) % MEM;
    startCond();
    sendByte(devCode(1'b0), 1'b0, "R7");
    sendByte(a[15:8], 1'b0, "R7");
    sendByte(a[7:0], 1'b0, "R7");
    startCond();
    sendByte(devCode(1'b1), 1'b0, "R7");
    for (int k = 0; k < n; k++) readByte(k == n - 1, model[(ea + k) % MEM], req);
    stopCond();
  endtask

  task automatic waitBusy();
    repeat (BUSY + 100) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < MEM; i++) model[i] = 8'hFF;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R10: released after reset
    expectVal(8'h00, "R10");
    observe({7'b0, sdaPullLow});

    // R1: wrong strap bits and wrong family nibble are refused
    startCond();
    sendByte({4'b1010, 3'b010, 1'b0}, 1'b1, "R1");
    stopCond();
    startCond();
    sendByte({4'b1011, STRAP, 1'b0}, 1'b1, "R1");
    stopCond();

    // R10 / R7: erased contents after reset
    readSeq(16'h0005, 1, "R10");

    // R2: high address bits ignored, byte write
    wbuf[0] = 8'h9A;
    writeBytes(16'hFF12, 1, "R2");
    // R5: poll inside busy window is refused
    startCond();
    sendByte(devCode(1'b0), 1'b1, "R5");
    stopCond();
    waitBusy();
    startCond();
    sendByte(devCode(1'b0), 1'b0, "R5");
    stopCond();
    readSeq(16'h0012, 1, "R2");

    // R3: page write wraps inside its page
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44; wbuf[4] = 8'h55;
    writeBytes(16'h001E, 5, "R3");
    waitBusy();
    readSeq(16'h0018, 8, "R3");
    readSeq(16'h0020, 1, "R3");

    // R6: protected write
    wrProtect = 1'b1;
    startCond();
    sendByte(devCode(1'b0), 1'b0, "R6");
    sendByte(8'h00, 1'b0, "R6");
    sendByte(8'h30, 1'b0, "R6");
    sendByte(8'h77, 1'b1, "R6");
    stopCond();
    wrProtect = 1'b0;
    readSeq(16'h0030, 1, "R6");

    // R4: STOP in the middle of a data byte
    startCond();
    sendByte(devCode(1'b0), 1'b0, "R4");
    sendByte(8'h00, 1'b0, "R4");
    sendByte(8'h40, 1'b0, "R4");
    for (int i = 0; i < 4; i++) writeBit(1'b0);
    stopCond();
    readSeq(16'h0040, 1, "R4");

    // R4: repeated START after a data byte drops it, no busy follows
    startCond();
    sendByte(devCode(1'b0), 1'b0, "R4");
    sendByte(8'h00, 1'b0, "R4");
    sendByte(8'h41, 1'b0, "R4");
    sendByte(8'h5A, 1'b0, "R4");
    startCond();
    sendByte(devCode(1'b0), 1'b0, "R4");
    stopCond();
    readSeq(16'h0041, 1, "R4");

    // R8: sequential read crosses the array top
    wbuf[0] = 8'hA5;
    writeBytes(16'h007F, 1, "R8");
    waitBusy();
    wbuf[0] = 8'h3C;
    writeBytes(16'h0000, 1, "R8");
    waitBusy();
    readSeq(16'h007E, 3, "R8");

    repeat (20) @(negedge clk);
    if (expQ.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL scoreboard actual %0d pending expected 0", expQ.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule